// File: doc/BRIEF.md
# Threshold-Driven UART Flow Controller

This block decides when a UART may send and when it must ask its peer to stop. It compares the fill level of the local receive FIFO against two programmable thresholds, a halt level and a lower resume level, both held in one 8-bit threshold register. It keeps a registered "local receiver congested" state with hysteresis between those levels. From that state it can drive the RTS modem line, or it can ask the transmitter to send in-band Xoff and Xon characters. On the receive side it watches incoming characters for Xoff and Xon so that local data transmission pauses when the peer asks it to. The same permission output also carries the CTS gate.

The transmitter is expected to start a new data character only while `tx_data_ok` is high. The gate acts only on character starts, so a character already being shifted always completes. A flow-control character is offered on `fc_req`/`fc_char` and takes precedence over FIFO data. The transmitter pulses `fc_ack` when it has taken the character.

Top module: `uart_flow_ctrl`

## Requirements
- R1: Under reset and in the first cycle after it, `fc_req` is 0, the congested state is clear (so `rts` is 1 with auto-RTS on), and `tx_data_ok` is 1 when auto-CTS is off or `cts` has been high.
- R2: The halt level is `thresh_cfg[3:0]`*4 and the resume level is `thresh_cfg[7:4]`*4. The congested state sets one clock after `rx_level` reaches or exceeds the halt level. It clears one clock after `rx_level` falls to or below the resume level. Between the two levels it keeps its value.
- R3: With `auto_rts_en`=1, `rts` is 1 exactly when the congested state is clear. With `auto_rts_en`=0, `rts` follows `man_rts`.
- R4: If the halt level is not greater than the resume level, the congested state is cleared one clock later and is never set.
- R5: With `auto_cts_en`=1, `tx_data_ok` goes low one clock after `cts` is sampled low. With `auto_cts_en`=0, `cts` has no effect.
- R6: `sw_mode[3:2]` selects the characters to send: 00 none, 01 Xon1/Xoff1, 10 Xon2/Xoff2, 11 both. When the congested state sets, an Xoff request is raised in the same clock. When it clears, an Xon request is raised.
- R7: In mode 11 a request sends character 1 first and then character 2. Each `fc_ack` advances one step, and the request ends after the second acknowledgement.
- R8: A request stays raised with the same character until acknowledged. It is raised once per threshold crossing. A new crossing replaces a request that is still pending.
- R9: While `fc_req` is 1, `tx_data_ok` is 0.
- R10: `sw_mode[1:0]` selects the characters to recognise: bit 0 enables Xon1/Xoff1 and bit 1 enables Xon2/Xoff2. A recognised Xoff received with `rx_char_valid` drops `tx_data_ok` from the next clock. A recognised Xon restores it.
- R11: With `any_char_resume`=1, any received character that is not a recognised Xoff ends a remote halt. With `any_char_resume`=0, a character that is not recognised has no effect.
- R12: With `sw_mode[1:0]`=00, received characters never halt transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_level | input | 7 | Receive FIFO fill level, 0 to 64 |
| thresh_cfg | input | 8 | [3:0] halt nibble, [7:4] resume nibble |
| auto_rts_en | input | 1 | RTS driven from the congested state |
| auto_cts_en | input | 1 | Data starts gated by CTS |
| man_rts | input | 1 | RTS value when auto-RTS is off |
| sw_mode | input | 4 | [3:2] send selection, [1:0] recognise selection |
| any_char_resume | input | 1 | Any received character ends a remote halt |
| xon1 | input | 8 | First Xon character |
| xon2 | input | 8 | Second Xon character |
| xoff1 | input | 8 | First Xoff character |
| xoff2 | input | 8 | Second Xoff character |
| rx_char_valid | input | 1 | Received-character strobe |
| rx_char | input | 8 | Received character |
| cts | input | 1 | Clear-to-send, 1 = peer ready |
| fc_ack | input | 1 | Transmitter took the flow-control character |
| rts | output | 1 | Request-to-send, 1 = ready to receive |
| tx_data_ok | output | 1 | Transmitter may start a data character |
| fc_req | output | 1 | Flow-control character pending |
| fc_char | output | 8 | Flow-control character to send |

## Verification
The bench holds the FIFO level between the two thresholds to show hysteresis. A design that compared against a single level would toggle RTS there. It programs equal and inverted thresholds, where a wrong design would halt for ever or never resume. It leaves an Xon request unacknowledged across a new halt crossing, and it uses the two-character mode, where a design that skips the second character or resends the first would show the wrong `fc_char` after the first acknowledgement. It also sends Xoff2 while only slot 1 is recognised, and sends ordinary characters with any-character resume both off and on, which catches match logic that ignores the selection bits.

// File: rtl/uart_fc_pkg.sv
// Shared constants and types for the UART flow controller.
// Assumes two programmable Xon and two Xoff character slots.
package uart_fc_pkg;
    localparam int FC_SLOTS = 2;

    typedef enum logic [1:0] {
        FC_NONE = 2'b00,
        FC_XOFF = 2'b01,
        FC_XON  = 2'b10
    } fc_kind_e;
endpackage

// File: rtl/uart_fc_thresh.sv
// Threshold tracker: scales the halt and resume nibbles to FIFO levels and
// keeps a registered congested state with hysteresis. It emits one-cycle
// events on the next-state edges. It assumes rx_level never exceeds the FIFO depth.
module uart_fc_thresh #(
    parameter int LEVEL_W  = 7,
    parameter int NIB_W    = 4,
    parameter int SCALE_SH = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LEVEL_W-1:0]   rx_level,
    input  logic [2*NIB_W-1:0]   thresh_cfg,
    output logic                 congested,
    output logic                 evt_halt,
    output logic                 evt_resume
);
    logic [LEVEL_W-1:0] halt_lvl;
    logic [LEVEL_W-1:0] resume_lvl;
    logic               thr_valid;
    logic               cong_q;
    logic               cong_d;

    // Scale each nibble to a FIFO level and check that the pair is usable.
    always_comb begin
        halt_lvl   = LEVEL_W'(thresh_cfg[NIB_W-1:0]) << SCALE_SH;
        resume_lvl = LEVEL_W'(thresh_cfg[2*NIB_W-1:NIB_W]) << SCALE_SH;
        thr_valid  = halt_lvl > resume_lvl;
    end

    // Next congested state, with the hysteresis band between the levels.
    always_comb begin
        cong_d = cong_q;
        if (!thr_valid)
            cong_d = 1'b0;
        else if (rx_level >= halt_lvl)
            cong_d = 1'b1;
        else if (rx_level <= resume_lvl)
            cong_d = 1'b0;
    end

    // Hold the congested state.
    always_ff @(posedge clk) begin
        if (!rst_n) cong_q <= 1'b0;
        else        cong_q <= cong_d;
    end

    // Crossing events and the state output.
    always_comb begin
        congested  = cong_q;
        evt_halt   = cong_d & ~cong_q;
        evt_resume = ~cong_d & cong_q;
    end

    assert_halt_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (thr_valid && rx_level >= halt_lvl) |=> congested);

    assert_invalid_thr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!thr_valid) |=> !congested);
endmodule

// File: rtl/uart_fc_rxdet.sv
// Received-character detector: compares each received character with the
// enabled Xon and Xoff slots and keeps the remote-halt state.
// It assumes rx_char is valid only while rx_char_valid is high.
module uart_fc_rxdet
    import uart_fc_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [FC_SLOTS-1:0]              rx_sel,
    input  logic                             any_char_resume,
    input  logic [FC_SLOTS-1:0][CHAR_W-1:0]  xon_set,
    input  logic [FC_SLOTS-1:0][CHAR_W-1:0]  xoff_set,
    input  logic                             rx_char_valid,
    input  logic [CHAR_W-1:0]                rx_char,
    output logic                             remote_halt
);
    logic [FC_SLOTS-1:0] hit_on;
    logic [FC_SLOTS-1:0] hit_off;
    logic                hit_xon;
    logic                hit_xoff;
    logic                halt_q;

    // One comparator pair per enabled character slot.
    for (genvar k = 0; k < FC_SLOTS; k++) begin : g_slot
        assign hit_on[k]  = rx_sel[k] && (rx_char == xon_set[k]);
        assign hit_off[k] = rx_sel[k] && (rx_char == xoff_set[k]);
    end

    // Merge the per-slot hits.
    always_comb begin
        hit_xon  = |hit_on;
        hit_xoff = |hit_off;
    end

    // Remote halt: Xoff sets it; Xon, or any character when allowed, clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            halt_q <= 1'b0;
        else if (rx_sel == '0)
            halt_q <= 1'b0;
        else if (rx_char_valid) begin
            if (hit_xoff)
                halt_q <= 1'b1;
            else if (hit_xon || any_char_resume)
                halt_q <= 1'b0;
        end
    end

    assign remote_halt = halt_q;

    assert_xoff_halts_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_char_valid && hit_xoff) |=> remote_halt);

    assert_any_resume_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_char_valid && any_char_resume && !hit_xoff) |=> !remote_halt);
endmodule

// File: rtl/uart_fc_txreq.sv
// Flow-control character requester: turns crossing events into pending
// Xoff/Xon requests and steps through one or two characters on each
// acknowledgement. It assumes fc_ack is only meaningful while fc_req is high.
module uart_fc_txreq
    import uart_fc_pkg::*;
#(
    parameter int CHAR_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic [FC_SLOTS-1:0]              tx_sel,
    input  logic [FC_SLOTS-1:0][CHAR_W-1:0]  xon_set,
    input  logic [FC_SLOTS-1:0][CHAR_W-1:0]  xoff_set,
    input  logic                             evt_halt,
    input  logic                             evt_resume,
    input  logic                             fc_ack,
    output logic                             fc_req,
    output logic [CHAR_W-1:0]                fc_char
);
    localparam int IDX_W = $clog2(FC_SLOTS);

    fc_kind_e         kind_q;
    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] slot;
    logic             seq_mode;
    logic             last_step;

    // Choose the slot being sent and whether this step ends the request.
    always_comb begin
        seq_mode  = (tx_sel == '1);
        if (seq_mode)
            slot = idx_q;
        else if (tx_sel[1])
            slot = IDX_W'(1);
        else
            slot = '0;
        last_step = !seq_mode || (idx_q == IDX_W'(FC_SLOTS - 1));
    end

    // Pending request: a new crossing overrides; an ack advances or clears.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q <= FC_NONE;
            idx_q  <= '0;
        end else if (tx_sel != '0 && evt_halt) begin
            kind_q <= FC_XOFF;
            idx_q  <= '0;
        end else if (tx_sel != '0 && evt_resume) begin
            kind_q <= FC_XON;
            idx_q  <= '0;
        end else if (kind_q != FC_NONE && fc_ack) begin
            if (last_step) begin
                kind_q <= FC_NONE;
                idx_q  <= '0;
            end else begin
                idx_q  <= idx_q + IDX_W'(1);
            end
        end
    end

    // Present the request and the selected character.
    always_comb begin
        fc_req  = (kind_q != FC_NONE);
        fc_char = (kind_q == FC_XOFF) ? xoff_set[slot] : xon_set[slot];
    end

    assert_req_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_req && !fc_ack) |=> fc_req);

    assert_second_char_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fc_req && fc_ack && seq_mode && idx_q == '0 && !evt_halt && !evt_resume)
        |=> (fc_req && idx_q != '0));
endmodule

// File: rtl/uart_flow_ctrl.sv
// UART flow controller top: combines the threshold tracker, the
// received-character detector and the flow-character requester. It drives RTS
// and the data-start permission. It assumes the transmitter starts a data
// character only while tx_data_ok is high and finishes any character already started.
module uart_flow_ctrl
    import uart_fc_pkg::*;
#(
    parameter int FIFO_DEPTH = 64,
    parameter int NIB_W      = 4,
    parameter int CHAR_W     = 8,
    localparam int LEVEL_W   = $clog2(FIFO_DEPTH + 1),
    localparam int SCALE_SH  = $clog2(FIFO_DEPTH) - NIB_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [LEVEL_W-1:0]   rx_level,
    input  logic [2*NIB_W-1:0]   thresh_cfg,
    input  logic                 auto_rts_en,
    input  logic                 auto_cts_en,
    input  logic                 man_rts,
    input  logic [3:0]           sw_mode,
    input  logic                 any_char_resume,
    input  logic [CHAR_W-1:0]    xon1,
    input  logic [CHAR_W-1:0]    xon2,
    input  logic [CHAR_W-1:0]    xoff1,
    input  logic [CHAR_W-1:0]    xoff2,
    input  logic                 rx_char_valid,
    input  logic [CHAR_W-1:0]    rx_char,
    input  logic                 cts,
    input  logic                 fc_ack,
    output logic                 rts,
    output logic                 tx_data_ok,
    output logic                 fc_req,
    output logic [CHAR_W-1:0]    fc_char
);
    logic [FC_SLOTS-1:0][CHAR_W-1:0] xon_set;
    logic [FC_SLOTS-1:0][CHAR_W-1:0] xoff_set;
    logic congested;
    logic evt_halt;
    logic evt_resume;
    logic remote_halt;
    logic cts_q;

    // Pack the character registers into slot arrays.
    always_comb begin
        xon_set[0]  = xon1;
        xon_set[1]  = xon2;
        xoff_set[0] = xoff1;
        xoff_set[1] = xoff2;
    end

    uart_fc_thresh #(
        .LEVEL_W  (LEVEL_W),
        .NIB_W    (NIB_W),
        .SCALE_SH (SCALE_SH)
    ) u_thresh (
        .clk        (clk),
        .rst_n      (rst_n),
        .rx_level   (rx_level),
        .thresh_cfg (thresh_cfg),
        .congested  (congested),
        .evt_halt   (evt_halt),
        .evt_resume (evt_resume)
    );

    uart_fc_rxdet #(.CHAR_W(CHAR_W)) u_rxdet (
        .clk             (clk),
        .rst_n           (rst_n),
        .rx_sel          (sw_mode[1:0]),
        .any_char_resume (any_char_resume),
        .xon_set         (xon_set),
        .xoff_set        (xoff_set),
        .rx_char_valid   (rx_char_valid),
        .rx_char         (rx_char),
        .remote_halt     (remote_halt)
    );

    uart_fc_txreq #(.CHAR_W(CHAR_W)) u_txreq (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_sel     (sw_mode[3:2]),
        .xon_set    (xon_set),
        .xoff_set   (xoff_set),
        .evt_halt   (evt_halt),
        .evt_resume (evt_resume),
        .fc_ack     (fc_ack),
        .fc_req     (fc_req),
        .fc_char    (fc_char)
    );

    // Register the CTS line before it gates character starts.
    always_ff @(posedge clk) begin
        if (!rst_n) cts_q <= 1'b1;
        else        cts_q <= cts;
    end

    // Modem output and data-start permission.
    always_comb begin
        rts        = auto_rts_en ? ~congested : man_rts;
        tx_data_ok = (~auto_cts_en | cts_q) & ~remote_halt & ~fc_req;
    end

    assert_cts_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (auto_cts_en && !cts) ##1 auto_cts_en |-> !tx_data_ok);

    assert_fc_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_halt && sw_mode[3:2] != 2'b00) |=> !tx_data_ok);
endmodule

// File: tb/tb_uart_flow_ctrl.sv
// Scoreboard bench: the driver applies a stimulus and queues the expected outputs;
// the monitor compares them 2 ns after each rising edge.
module tb_uart_flow_ctrl;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [6:0] rx_level;
    logic [7:0] thresh_cfg;
    logic       auto_rts_en, auto_cts_en, man_rts;
    logic [3:0] sw_mode;
    logic       any_char_resume;
    logic [7:0] xon1, xon2, xoff1, xoff2;
    logic       rx_char_valid;
    logic [7:0] rx_char;
    logic       cts, fc_ack;
    logic       rts, tx_data_ok, fc_req;
    logic [7:0] fc_char;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    typedef struct {
        string      tag;
        logic       rts;
        logic       ok;
        logic       req;
        logic [7:0] chr;
    } exp_t;
    exp_t sb[$];

    always #4 clk = ~clk;

    uart_flow_ctrl dut (
        .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .thresh_cfg(thresh_cfg),
        .auto_rts_en(auto_rts_en), .auto_cts_en(auto_cts_en), .man_rts(man_rts),
        .sw_mode(sw_mode), .any_char_resume(any_char_resume),
        .xon1(xon1), .xon2(xon2), .xoff1(xoff1), .xoff2(xoff2),
        .rx_char_valid(rx_char_valid), .rx_char(rx_char), .cts(cts), .fc_ack(fc_ack),
        .rts(rts), .tx_data_ok(tx_data_ok), .fc_req(fc_req), .fc_char(fc_char)
    );

    // Driver step: the inputs are already set; wait one edge, queue the expectation, return at the falling edge.
    task automatic cyc(input logic e_rts, input logic e_ok, input logic e_req,
                       input logic [7:0] e_chr, input string tag);
        exp_t e;
        @(posedge clk);
        e.tag = tag; e.rts = e_rts; e.ok = e_ok; e.req = e_req; e.chr = e_chr;
        sb.push_back(e);
        @(negedge clk);
    endtask

    // Monitor: pop and compare every queued expectation after the edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                n_vec++;
                if (rts !== e.rts || tx_data_ok !== e.ok || fc_req !== e.req ||
                    (e.req && fc_char !== e.chr)) begin
                    n_fail++;
                    $display("FAIL %s: got rts=%b ok=%b req=%b chr=%h, expected rts=%b ok=%b req=%b chr=%h",
                             e.tag, rts, tx_data_ok, fc_req, fc_char,
                             e.rts, e.ok, e.req, e.chr);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(200000 * 8);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; rx_level = '0; thresh_cfg = 8'h48;
        auto_rts_en = 1'b1; auto_cts_en = 1'b1; man_rts = 1'b1;
        sw_mode = 4'b0000; any_char_resume = 1'b0;
        xon1 = 8'h11; xon2 = 8'h91; xoff1 = 8'h13; xoff2 = 8'h93;
        rx_char_valid = 1'b0; rx_char = '0; cts = 1'b1; fc_ack = 1'b0;
        @(negedge clk);
        cyc(1, 1, 0, 8'h00, "R1 during reset");
        rst_n = 1'b1;
        cyc(1, 1, 0, 8'h00, "R1 after reset");

        // Hysteresis: halt level 32, resume level 16.
        rx_level = 7'd31; cyc(1, 1, 0, 8'h00, "R2 below halt level");
        rx_level = 7'd32; cyc(0, 1, 0, 8'h00, "R2 R3 halt at level");
        rx_level = 7'd20; cyc(0, 1, 0, 8'h00, "R2 hold inside band");
        rx_level = 7'd16; cyc(1, 1, 0, 8'h00, "R2 R3 resume at level");
        auto_rts_en = 1'b0; man_rts = 1'b0;
        cyc(0, 1, 0, 8'h00, "R3 manual rts");
        auto_rts_en = 1'b1; man_rts = 1'b1;

        // Threshold pairs that are not usable.
        thresh_cfg = 8'h44; rx_level = 7'd40;
        cyc(1, 1, 0, 8'h00, "R4 equal levels never halt");
        thresh_cfg = 8'h48; cyc(0, 1, 0, 8'h00, "R4 valid pair halts");
        thresh_cfg = 8'h52; cyc(1, 1, 0, 8'h00, "R4 inverted pair clears");
        thresh_cfg = 8'h48; rx_level = 7'd0;
        cyc(1, 1, 0, 8'h00, "R2 idle");

        // CTS gating.
        cts = 1'b0; cyc(1, 0, 0, 8'h00, "R5 cts low blocks");
        auto_cts_en = 1'b0; cyc(1, 1, 0, 8'h00, "R5 cts ignored when off");
        auto_cts_en = 1'b1; cts = 1'b1; cyc(1, 1, 0, 8'h00, "R5 cts high");

        // Single-slot send mode.
        sw_mode = 4'b0100; rx_level = 7'd32;
        cyc(0, 0, 1, 8'h13, "R6 R9 xoff1 requested");
        cyc(0, 0, 1, 8'h13, "R8 held until ack");
        fc_ack = 1'b1; cyc(0, 1, 0, 8'h00, "R8 cleared by ack");
        fc_ack = 1'b0; rx_level = 7'd40;
        cyc(0, 1, 0, 8'h00, "R8 once per crossing");
        rx_level = 7'd16; cyc(1, 0, 1, 8'h11, "R6 R9 xon1 requested");
        fc_ack = 1'b1; cyc(1, 1, 0, 8'h00, "R8 xon acked");
        fc_ack = 1'b0;

        // Two-character mode.
        sw_mode = 4'b1100; rx_level = 7'd32;
        cyc(0, 0, 1, 8'h13, "R7 first xoff");
        fc_ack = 1'b1; cyc(0, 0, 1, 8'h93, "R7 second xoff");
        cyc(0, 1, 0, 8'h00, "R7 sequence done");
        fc_ack = 1'b0;

        // Replacement of a pending request.
        sw_mode = 4'b0100; rx_level = 7'd0;
        cyc(1, 0, 1, 8'h11, "R6 xon pending");
        rx_level = 7'd32; cyc(0, 0, 1, 8'h13, "R8 new crossing replaces");
        fc_ack = 1'b1; cyc(0, 1, 0, 8'h00, "R8 replaced req acked");
        fc_ack = 1'b0; rx_level = 7'd0;
        cyc(1, 0, 1, 8'h11, "R6 xon after replace");
        fc_ack = 1'b1; cyc(1, 1, 0, 8'h00, "R8 acked");
        fc_ack = 1'b0;

        // Slot 2 send mode.
        sw_mode = 4'b1000; rx_level = 7'd32;
        cyc(0, 0, 1, 8'h93, "R6 xoff2 requested");
        fc_ack = 1'b1; cyc(0, 1, 0, 8'h00, "R6 xoff2 acked");
        fc_ack = 1'b0; rx_level = 7'd0;
        cyc(1, 0, 1, 8'h91, "R6 xon2 requested");
        fc_ack = 1'b1; cyc(1, 1, 0, 8'h00, "R6 xon2 acked");
        fc_ack = 1'b0;

        // Received-character detection, slot 1 only.
        sw_mode = 4'b0001;
        rx_char_valid = 1'b1; rx_char = 8'h13;
        cyc(1, 0, 0, 8'h00, "R10 xoff1 halts");
        rx_char_valid = 1'b0; cyc(1, 0, 0, 8'h00, "R10 halt holds");
        rx_char_valid = 1'b1; rx_char = 8'h41;
        cyc(1, 0, 0, 8'h00, "R11 plain char ignored");
        rx_char = 8'h11; cyc(1, 1, 0, 8'h00, "R10 xon1 resumes");
        rx_char = 8'h93; cyc(1, 1, 0, 8'h00, "R10 xoff2 not enabled");
        any_char_resume = 1'b1; rx_char = 8'h13;
        cyc(1, 0, 0, 8'h00, "R10 xoff1 halts again");
        rx_char = 8'h41; cyc(1, 1, 0, 8'h00, "R11 any char resumes");
        sw_mode = 4'b0000; rx_char = 8'h13;
        cyc(1, 1, 0, 8'h00, "R12 detection off");
        rx_char_valid = 1'b0;
        cyc(1, 1, 0, 8'h00, "R12 still running");

        @(posedge clk); #3;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule